// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Controller

This block gathers a set of level-sensitive interrupt lines, organised as banks of 32 sources (three banks by default), and turns them into two requests for a processor: an ordinary interrupt request and a fast interrupt request. Software sees it through a plain 32-bit register port with single-cycle accesses inside a 1 KiB window. The port covers per-bank registers for pending state, masking, fast-path routing, enable flags and a fast-pending array. It also has four global words: a vector, a base address, a protect word and an NMI-control word.

Each cycle the controller looks at which sources are high and not masked. It raises the ordinary request if there is any such source. It raises the fast request if at least one of them is also routed to the fast path. It computes a byte offset, four times the index of the lowest such source, which software reads from the vector word to dispatch straight to a handler. The two requests and the vector are registered. They reflect the inputs seen at a clock edge and the register contents held before that edge, and they appear one clock later.

Top module: `vic_top`

## Requirements
- R1: The pending word of bank b (offset 0x10 + 4*b) reads, in each cycle, the input levels of sources 32*b to 32*b+31 sampled at the previous clock edge (bit n = source 32*b+n).
- R2: `irq_o` is 1 in the cycle after an edge exactly when some input was high at that edge and its mask bit (offset 0x50 + 4*b, 1 = blocked) was 0 before that edge.
- R3: `fiq_o` follows the R2 rule but counts only sources whose select bit (offset 0x30 + 4*b, 1 = fast path) is also 1.
- R4: The vector word (offset 0x00) holds 4 times the index of the lowest-numbered source counted by R2, taken at the same edge and in the same cycle as R2. It holds 0 when no source counts. Source 95 gives 0x17C.
- R5: Writes to the pending words change nothing.
- R6: The fast-pending words (offset 0x20 + 4*b) clear each bit written as 1 and keep the others. Nothing sets them, so they read 0.
- R7: A write to the base-address word (offset 0x04) stores the data with bits [1:0] forced to 0.
- R8: The select, enable and mask words and the protect (0x08) and NMI (0x0C) words read back the last value written to them, with address bits [3:2] choosing the bank.
- R9: A synchronous active-high reset clears every register, both requests and the vector.
- R10: Offsets that are unaligned, that are a bank slot at or beyond the bank count (such as 0x1C), or that lie outside 0x00 to 0x5F read 0, and writing to them changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | NUM_BANKS*DATA_W | Level interrupt inputs, bit i = source i |
| bus_addr_i | input | 10 | Byte offset inside the register window |
| bus_we_i | input | 1 | Write strobe, applied at the clock edge |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Ordinary interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
Two things can happen in the same cycle: an input line changes and software rewrites a mask or select word. When both land on one edge, the requests and the vector must be judged against the new input levels and the old mask. The bench provokes this both in a directed step and many times in a randomised phase, where mask and select writes often coincide with changes on the lines. A behavioural model steps through every edge, taking the input levels and the pre-edge register copies first and applying the write afterwards. The model is compared with `irq_o`, `fiq_o` and the read data on every clock. The read address rests on the vector word while idle, so the vector is compared each cycle as well.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int ADDR_W = 10;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_VEC,
        RK_BASE,
        RK_PROT,
        RK_NMI,
        RK_PEND,
        RK_FPEND,
        RK_SEL,
        RK_EN,
        RK_MASK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] bank;
    } reg_sel_t;

    // Offset decode: group = addr[9:4], word/bank = addr[3:2]
    function automatic reg_sel_t decode_addr(logic [ADDR_W-1:0] addr, int nb);
        reg_sel_t r;
        logic [ADDR_W-5:0] grp;
        r.kind = RK_NONE;
        r.bank = addr[3:2];
        grp    = addr[ADDR_W-1:4];
        if (addr[1:0] == 2'b00) begin
            if (grp == '0) begin
                case (addr[3:2])
                    2'd0:    r.kind = RK_VEC;
                    2'd1:    r.kind = RK_BASE;
                    2'd2:    r.kind = RK_PROT;
                    default: r.kind = RK_NMI;
                endcase
            end else if (int'(addr[3:2]) < nb) begin
                case (int'(grp))
                    1:       r.kind = RK_PEND;
                    2:       r.kind = RK_FPEND;
                    3:       r.kind = RK_SEL;
                    4:       r.kind = RK_EN;
                    5:       r.kind = RK_MASK;
                    default: r.kind = RK_NONE;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/vic_regfile.sv
module vic_regfile
    import vic_pkg::*;
#(
    parameter int NB = 3,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NB*DW-1:0] src_i,
    input  logic             we_i,
    input  reg_sel_t         sel_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [DW-1:0]    vec_i,
    output logic [DW-1:0]    rdata_o,
    output logic [NB*DW-1:0] mask_o,
    output logic [NB*DW-1:0] route_o
);

    logic [NB-1:0][DW-1:0] pend_r, fpend_r, route_r, en_r, mask_r;
    logic [DW-1:0] base_r, prot_r, nmi_r;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            always_ff @(posedge clk) begin
                if (rst) begin
                    pend_r[b]  <= '0;
                    fpend_r[b] <= '0;
                    route_r[b] <= '0;
                    en_r[b]    <= '0;
                    mask_r[b]  <= '0;
                end else begin
                    pend_r[b] <= src_i[b*DW +: DW];
                    if (we_i && int'(sel_i.bank) == b) begin
                        case (sel_i.kind)
                            RK_FPEND: fpend_r[b] <= fpend_r[b] & ~wdata_i;
                            RK_SEL:   route_r[b] <= wdata_i;
                            RK_EN:    en_r[b]    <= wdata_i;
                            RK_MASK:  mask_r[b]  <= wdata_i;
                            default:  ;
                        endcase
                    end
                end
            end
            assign mask_o[b*DW +: DW]  = mask_r[b];
            assign route_o[b*DW +: DW] = route_r[b];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            base_r <= '0;
            prot_r <= '0;
            nmi_r  <= '0;
        end else if (we_i) begin
            case (sel_i.kind)
                RK_BASE: base_r <= {wdata_i[DW-1:2], 2'b00};
                RK_PROT: prot_r <= wdata_i;
                RK_NMI:  nmi_r  <= wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel_i.kind)
            RK_VEC:   rdata_o = vec_i;
            RK_BASE:  rdata_o = base_r;
            RK_PROT:  rdata_o = prot_r;
            RK_NMI:   rdata_o = nmi_r;
            RK_PEND:  rdata_o = pend_r[sel_i.bank];
            RK_FPEND: rdata_o = fpend_r[sel_i.bank];
            RK_SEL:   rdata_o = route_r[sel_i.bank];
            RK_EN:    rdata_o = en_r[sel_i.bank];
            RK_MASK:  rdata_o = mask_r[sel_i.bank];
            default:  rdata_o = '0;
        endcase
    end

    // R1: pending tracks the lines one edge later, pending writes included (R5)
    assert_pend_follows_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pend_r == $past(src_i));

    // R6: bits written as one are clear afterwards
    assert_fpend_w1c_R6: assert property (@(posedge clk) disable iff (rst)
        (we_i && sel_i.kind == RK_FPEND)
        |=> (fpend_r[$past(sel_i.bank)] & $past(wdata_i)) == '0);

    // R8: mask write is stored as written
    assert_mask_store_R8: assert property (@(posedge clk) disable iff (rst)
        (we_i && sel_i.kind == RK_MASK)
        |=> mask_r[$past(sel_i.bank)] == $past(wdata_i));

    // R10: unmapped writes leave every writable register untouched
    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (rst)
        (we_i && sel_i.kind == RK_NONE)
        |=> $stable(route_r) && $stable(mask_r) && $stable(en_r) && $stable(fpend_r)
            && $stable(base_r) && $stable(prot_r) && $stable(nmi_r));

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int NB = 3,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NB*DW-1:0] src_i,
    input  logic [NB*DW-1:0] mask_i,
    input  logic [NB*DW-1:0] route_i,
    output logic             irq_o,
    output logic             fiq_o,
    output logic [DW-1:0]    vec_o
);

    localparam int NSRC = NB * DW;

    logic [NSRC-1:0] live;
    logic            irq_d, fiq_d;
    logic [DW-1:0]   vec_d;

    always_comb begin
        live  = src_i & ~mask_i;
        irq_d = |live;
        fiq_d = |(live & route_i);
        vec_d = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (live[i]) vec_d = DW'(i * 4);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
            vec_o <= '0;
        end else begin
            irq_o <= irq_d;
            fiq_o <= fiq_d;
            vec_o <= vec_d;
        end
    end

    // R3: a fast request always comes with an ordinary one
    assert_fiq_implies_irq_R3: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> irq_o);

    // R4: a nonzero vector means a request is up
    assert_vec_needs_irq_R4: assert property (@(posedge clk) disable iff (rst)
        (vec_o != '0) |-> irq_o);

    // R4: vector is a word offset
    assert_vec_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        vec_o[1:0] == 2'b00);

    // R9: reset clears both requests and the vector
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!irq_o && !fiq_o && vec_o == '0));

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int DATA_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_BANKS*DATA_W-1:0] irq_src_i,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic                        bus_we_i,
    input  logic [DATA_W-1:0]           bus_wdata_i,
    output logic [DATA_W-1:0]           bus_rdata_o,
    output logic                        irq_o,
    output logic                        fiq_o
);

    localparam int NSRC = NUM_BANKS * DATA_W;

    reg_sel_t          acc_sel;
    logic [NSRC-1:0]   mask_w, route_w;
    logic [DATA_W-1:0] vec_w;

    assign acc_sel = decode_addr(bus_addr_i, NUM_BANKS);

    vic_regfile #(.NB(NUM_BANKS), .DW(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .src_i   (irq_src_i),
        .we_i    (bus_we_i),
        .sel_i   (acc_sel),
        .wdata_i (bus_wdata_i),
        .vec_i   (vec_w),
        .rdata_o (bus_rdata_o),
        .mask_o  (mask_w),
        .route_o (route_w)
    );

    vic_prio #(.NB(NUM_BANKS), .DW(DATA_W)) u_prio (
        .clk     (clk),
        .rst     (rst),
        .src_i   (irq_src_i),
        .mask_i  (mask_w),
        .route_i (route_w),
        .irq_o   (irq_o),
        .fiq_o   (fiq_o),
        .vec_o   (vec_w)
    );

endmodule

// File: tb/sim_vic_top.sv
module sim_vic_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [95:0] src = '0;
    logic [9:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    always #5 clk = ~clk;

    vic_top u0 (
        .clk(clk), .rst(rst), .irq_src_i(src), .bus_addr_i(addr),
        .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    // behavioural model
    logic [31:0] m_pend[3], m_fpend[3], m_sel[3], m_en[3], m_mask[3];
    logic [31:0] m_base, m_prot, m_nmi, m_vec;
    logic        m_irq, m_fiq;
    int          nchk = 0, nfail = 0;
    string       phase = "R9";

    // returns word kind: 0 none,1 vec,2 base,3 prot,4 nmi,5 pend,6 fpend,7 sel,8 en,9 mask
    function automatic int kind_of(input logic [9:0] a, output int bank);
        int ia;
        ia = int'(a);
        bank = 0;
        if (ia % 4 != 0) return 0;
        if (ia < 16) return 1 + ia / 4;
        for (int g = 1; g <= 5; g++) begin
            if (ia >= 16 * g && ia <= 16 * g + 8) begin
                bank = (ia - 16 * g) / 4;
                return 4 + g;
            end
        end
        return 0;
    endfunction

    function automatic logic [31:0] model_read(input logic [9:0] a);
        int b, k;
        k = kind_of(a, b);
        case (k)
            1: return m_vec;
            2: return m_base;
            3: return m_prot;
            4: return m_nmi;
            5: return m_pend[b];
            6: return m_fpend[b];
            7: return m_sel[b];
            8: return m_en[b];
            9: return m_mask[b];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [9:0] a);
        int b, k;
        k = kind_of(a, b);
        case (k)
            0: return "R10";
            1: return "R4";
            2: return "R7";
            5: return "R1";
            6: return "R6";
            default: return "R8";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 3; b++) begin
                m_pend[b] = '0; m_fpend[b] = '0; m_sel[b] = '0;
                m_en[b] = '0; m_mask[b] = '0;
            end
            m_base = '0; m_prot = '0; m_nmi = '0; m_vec = '0;
            m_irq = 1'b0; m_fiq = 1'b0;
        end else begin
            logic ni, nf;
            logic [31:0] nv;
            int bk, kd;
            bit found;
            ni = 1'b0; nf = 1'b0; nv = '0; found = 0;
            for (int i = 0; i < 96; i++) begin
                if (src[i] && !m_mask[i / 32][i % 32]) begin
                    ni = 1'b1;
                    if (m_sel[i / 32][i % 32]) nf = 1'b1;
                    if (!found) begin nv = i * 4; found = 1; end
                end
            end
            if (we) begin
                kd = kind_of(addr, bk);
                case (kd)
                    2: m_base = wdata & 32'hFFFF_FFFC;
                    3: m_prot = wdata;
                    4: m_nmi = wdata;
                    6: m_fpend[bk] = m_fpend[bk] & ~wdata;
                    7: m_sel[bk] = wdata;
                    8: m_en[bk] = wdata;
                    9: m_mask[bk] = wdata;
                    default: ;
                endcase
            end
            for (int b = 0; b < 3; b++) m_pend[b] = src[32 * b +: 32];
            m_irq = ni; m_fiq = nf; m_vec = nv;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        logic [31:0] er;
        er = model_read(addr);
        nchk++;
        if (irq !== m_irq) begin
            nfail++;
            $display("FAIL %s/R2 irq_o got %0b expected %0b at %0t", phase, irq, m_irq, $time);
        end
        nchk++;
        if (fiq !== m_fiq) begin
            nfail++;
            $display("FAIL %s/R3 fiq_o got %0b expected %0b at %0t", phase, fiq, m_fiq, $time);
        end
        nchk++;
        if (rdata !== er) begin
            nfail++;
            $display("FAIL %s/%s rdata @%03h got %08h expected %08h at %0t",
                     phase, tag_of(addr), addr, rdata, er, $time);
        end
    end

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        step();
        addr = a; we = 1'b1; wdata = d;
        step();
        we = 1'b0; addr = '0;
    endtask

    task automatic rd(input logic [9:0] a);
        step();
        addr = a;
        step();
        addr = '0;
    endtask

    task automatic read_all();
        for (int a = 0; a < 'h60; a += 4) rd(10'(a));
    endtask

    bit done = 0;

    initial begin
        #(1_500_000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R9: everything reads zero after reset
        phase = "R9";
        read_all();

        // R8 / R7: readback and base alignment
        phase = "R8";
        wr(10'h004, 32'hFFFF_FFFF);
        wr(10'h008, 32'hA5A5_1234);
        wr(10'h00C, 32'h0000_0001);
        wr(10'h040, 32'h1111_0000);
        wr(10'h044, 32'h2222_0000);
        wr(10'h048, 32'h3333_0000);
        wr(10'h034, 32'h0000_00F0);
        read_all();

        // R4: highest source alone, then source zero
        phase = "R4";
        step(); src = '0; src[95] = 1'b1;
        rd(10'h000);
        step(); src = '0; src[0] = 1'b1;
        rd(10'h000);
        // R3: fast routing via bank 1 select bits 4..7
        phase = "R3";
        step(); src = '0; src[37] = 1'b1; src[70] = 1'b1;
        rd(10'h000);
        // R2: mask blocks bank 1 source, vector moves to 70
        phase = "R2";
        wr(10'h054, 32'h0000_0020);
        rd(10'h000);
        wr(10'h058, 32'hFFFF_FFFF);
        rd(10'h000);

        // R5: writing pending words has no effect
        phase = "R5";
        wr(10'h010, 32'hFFFF_FFFF);
        wr(10'h014, 32'h0);
        rd(10'h014);
        // R6: fast-pending clear
        phase = "R6";
        wr(10'h020, 32'hFFFF_FFFF);
        rd(10'h020);

        // R10: unmapped writes
        phase = "R10";
        wr(10'h01C, 32'hDEAD_BEEF);
        wr(10'h05C, 32'hDEAD_BEEF);
        wr(10'h3FC, 32'hDEAD_BEEF);
        wr(10'h031, 32'hDEAD_BEEF);
        wr(10'h060, 32'hDEAD_BEEF);
        rd(10'h01C); rd(10'h3FC); rd(10'h031);
        read_all();

        // line edge and mask write on the same edge
        phase = "R2";
        wr(10'h050, 32'h0); wr(10'h054, 32'h0); wr(10'h058, 32'h0);
        step(); src = '0;
        step();
        src[40] = 1'b1; addr = 10'h054; we = 1'b1; wdata = 32'h0000_0100;
        step(); we = 1'b0; addr = '0; src[40] = 1'b0;
        rd(10'h000);

        // randomised traffic
        phase = "RND";
        for (int n = 0; n < 600; n++) begin
            step();
            src = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
            if ($urandom_range(0, 2) == 0) src = '0;
            case ($urandom_range(0, 5))
                0: begin addr = 10'(16 * $urandom_range(3, 5) + 4 * $urandom_range(0, 2));
                         we = 1'b1; wdata = $urandom | $urandom; end
                1: begin addr = 10'($urandom_range(0, 'h5F)); we = 1'b1; wdata = $urandom; end
                2: begin addr = 10'($urandom_range(0, 'h3FF)); we = 1'b0; end
                default: begin addr = '0; we = 1'b0; end
            endcase
        end
        step(); we = 1'b0; addr = '0;
        read_all();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule